// File: doc/BRIEF.md
# Serial Transmitter with Selectable Empty Interrupt

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding register. When the shifter is idle, the byte moves into a shift register and goes out on the line as a frame of ten bits. The frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts a fixed number of baud ticks, and the ticks come from an external rate generator.

A control/status byte holds the software settings and the read-only status. One control bit chooses when the transmit-empty interrupt fires. In early mode it fires when the holding register hands its byte to the shifter, so software can refill it at once. In late mode it fires only after the last stop bit has left the line and nothing else is queued, which suits direction switching on half-duplex links. A break control holds the line low. While break is on, the shifter-empty status reads 0 and no new frame starts. A write that arrives while the holding register is still occupied is dropped and noted in a sticky flag.

Top module: `serial_tx_unit`

## Requirements
- R1: With control bit 0 clear, `irq` pulses high for one cycle, one clock after the holding register's byte is transferred into the shifter. This is the same cycle in which status bit 2 returns to 1.
- R2: With control bit 0 set, `irq` pulses only in the cycle in which the final stop bit ends and the holding register is empty. Two queued bytes give exactly one pulse.
- R3: Each frame on `txd` is a 0 start bit, then data bits 0 to 7 in order, then a 1 stop bit. Every bit lasts TICKS_PER_BIT (default 16) baud ticks.
- R4: Status bit 2 (holding empty) reads 0 from the clock after an accepted data write until the clock that moves the byte into the shifter. It reads 1 otherwise.
- R5: Status bit 1 (shifter empty, read-only) reads 1 only when no frame is in progress, no byte is held and break is off. It drops to 0 on the clock after a data write.
- R6: Control bit 3 (break) forces `txd` low, forces status bit 1 to 0 and keeps a held byte from starting. After release, `txd` is high and the held byte is then sent.
- R7: `irq` never pulses in a cycle that follows a cycle in which `txe_irq_en` was low.
- R8: After reset, `ctl_rdata` is 8'h06, `txd` is 1 and `irq` is 0.
- R9: A data write while status bit 2 is 0 is discarded and sets status bit 4. Bit 4 stays set until a control write with bit 4 set clears it.
- R10: Control bits 0 and 3 read back as written. Bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle baud rate pulse |
| data_we | input | 1 | Write strobe for the data byte |
| data_wval | input | DATA_W | Byte to transmit |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wval | input | 8 | Control value: bit 0 late-interrupt mode, bit 3 break, bit 4 write 1 to clear overwrite flag |
| txe_irq_en | input | 1 | Transmit-empty interrupt enable |
| ctl_rdata | output | 8 | Control/status readback |
| txd | output | 1 | Serial line, idle high |
| irq | output | 1 | One-cycle transmit-empty interrupt pulse |

## Verification
The assertions assume that `data_we` and `ctl_we` are single-cycle strobes and that `baud_tick` is a pulse no wider than one clock. They also assume that `txe_irq_en` is sampled on the same edge that registers the interrupt. The bench generates ticks on every third clock, issues every write for exactly one cycle, and turns break on only while the shifter is idle. A scoreboard decodes the line mid-bit, in tick units counted from the falling start edge, and pops one expected byte from a queue for each decoded frame.

// File: rtl/serial_tx_unit.sv
module serial_tx_unit #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wval,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wval,
  input  logic              txe_irq_en,
  output logic [7:0]        ctl_rdata,
  output logic              txd,
  output logic              irq
);
  localparam int FW = DATA_W + 2;
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BW = $clog2(FW + 1);

  logic              late_q, brk_q, ovw_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full, busy;
  logic [FW-1:0]     shreg;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bcnt;

  wire load    = !busy && hold_full && !brk_q;
  wire bit_end = busy && baud_tick && (tcnt == TW'(TICKS_PER_BIT - 1));
  wire done    = bit_end && (bcnt == BW'(FW - 1));
  wire wr_ok   = data_we && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_q <= 1'b0;
      brk_q  <= 1'b0;
      ovw_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        late_q <= ctl_wval[0];
        brk_q  <= ctl_wval[3];
      end
      if (data_we && hold_full) ovw_q <= 1'b1;
      else if (ctl_we && ctl_wval[4]) ovw_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (wr_ok) begin
      hold_q    <= data_wval;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      shreg <= {1'b1, hold_q, 1'b0};
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        bcnt  <= bcnt + 1'b1;
        if (done) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= txe_irq_en && ((load && !late_q) || (done && !hold_full && late_q));
  end

  assign txd       = !brk_q && (busy ? shreg[0] : 1'b1);
  assign ctl_rdata = {3'b000, ovw_q, brk_q, !hold_full, !busy && !hold_full && !brk_q, late_q};

  AST_EARLY_ON_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(late_q)) |-> $fell(hold_full)); // R1
  AST_LATE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(late_q)) |-> (!busy && $past(busy))); // R2
  AST_BREAK_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !busy) |=> !busy); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(txe_irq_en)); // R7
  AST_OVERWRITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovw_q) && !$past(ctl_we && ctl_wval[4])) |-> ovw_q); // R9
endmodule

// File: tb/serial_tx_unit_bench.sv
module serial_tx_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, baud_tick = 1'b0, data_we = 1'b0, ctl_we = 1'b0, txe_irq_en = 1'b0;
  logic [7:0] data_wval = '0, ctl_wval = '0;
  logic [7:0] ctl_rdata;
  logic       txd, irq;
  logic       mon_en = 1'b1;
  logic [7:0] exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  serial_tx_unit u_serial_tx_unit (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .data_we(data_we), .data_wval(data_wval),
    .ctl_we(ctl_we), .ctl_wval(ctl_wval), .txe_irq_en(txe_irq_en),
    .ctl_rdata(ctl_rdata), .txd(txd), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k = (k + 1) % 3;
      baud_tick = (k == 0);
    end
  end

  initial begin
    logic [7:0] got;
    int n, stp;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && txd === 1'b0) begin
        n = 0; while (n < 8) begin @(negedge clk); if (baud_tick) n++; end
        chk(txd == 1'b0, "R3 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          n = 0; while (n < 16) begin @(negedge clk); if (baud_tick) n++; end
          got[i] = txd;
        end
        n = 0; while (n < 16) begin @(negedge clk); if (baud_tick) n++; end
        stp = txd;
        chk(stp == 1, "R3 stop bit", stp, 1);
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected frame", got, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R3 frame data", got, e);
        end
      end
    end
  end

  task automatic put(input logic [7:0] b, input bit accepted);
    data_we = 1'b1; data_wval = b;
    if (accepted) exp_q.push_back(b);
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wval = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic count_until_idle(output int pulses, output bit early_seen);
    pulses = 0; early_seen = 0;
    do begin
      @(negedge clk);
      if (irq) begin
        pulses++;
        if (!ctl_rdata[1]) early_seen = 1;
      end
    end while (!ctl_rdata[1]);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int p;
    bit es;
    repeat (3) @(negedge clk);
    chk(ctl_rdata == 8'h06, "R8 reset status", ctl_rdata, 8'h06);
    chk(txd == 1'b1, "R8 reset line", txd, 1);
    chk(irq == 1'b0, "R8 reset irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    ctl(8'hE1);
    chk(ctl_rdata == 8'h07, "R10 readback", ctl_rdata, 8'h07);
    ctl(8'h00);
    chk(ctl_rdata == 8'h06, "R10 readback clear", ctl_rdata, 8'h06);

    txe_irq_en = 1'b1;
    put(8'hA5, 1);
    chk(ctl_rdata[2] == 1'b0, "R4 holding full", ctl_rdata[2], 0);
    chk(ctl_rdata[1] == 1'b0, "R5 cleared by write", ctl_rdata[1], 0);
    chk(irq == 1'b0, "R1 no irq before transfer", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R1 irq at transfer", irq, 1);
    chk(ctl_rdata[2] == 1'b1, "R4 holding empty after transfer", ctl_rdata[2], 1);
    chk(ctl_rdata[1] == 1'b0, "R5 busy frame", ctl_rdata[1], 0);
    count_until_idle(p, es);
    chk(ctl_rdata[1] == 1'b1, "R5 idle again", ctl_rdata[1], 1);

    ctl(8'h01);
    put(8'h3C, 1);
    count_until_idle(p, es);
    chk(!es, "R2 no irq mid frame", es, 0);
    chk(p == 1, "R2 single late irq", p, 1);

    put(8'h11, 1);
    @(negedge clk);
    put(8'h22, 1);
    count_until_idle(p, es);
    chk(!es && p == 1, "R2 one irq for two bytes", p, 1);

    ctl(8'h00);
    put(8'h55, 1);
    @(negedge clk);
    put(8'h66, 1);
    put(8'h77, 0);
    chk(ctl_rdata[4] == 1'b1, "R9 overwrite flag", ctl_rdata[4], 1);
    count_until_idle(p, es);
    count_until_idle(p, es);
    chk(ctl_rdata[4] == 1'b1, "R9 flag sticky", ctl_rdata[4], 1);
    ctl(8'h10);
    chk(ctl_rdata[4] == 1'b0, "R9 flag cleared", ctl_rdata[4], 0);

    txe_irq_en = 1'b0;
    put(8'h99, 1);
    count_until_idle(p, es);
    chk(p == 0, "R7 no irq when disabled", p, 0);
    txe_irq_en = 1'b1;

    put(8'h00, 1); count_until_idle(p, es);
    put(8'hFF, 1); count_until_idle(p, es);
    put(8'h80, 1); count_until_idle(p, es);
    put(8'h01, 1); count_until_idle(p, es);

    mon_en = 1'b0;
    ctl(8'h08);
    chk(txd == 1'b0, "R6 break line low", txd, 0);
    chk(ctl_rdata[1] == 1'b0, "R6 empty flag held off", ctl_rdata[1], 0);
    put(8'hC3, 1);
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R6 still low", txd, 0);
    chk(ctl_rdata[2] == 1'b0, "R6 byte not started", ctl_rdata[2], 0);
    mon_en = 1'b1;
    ctl(8'h00);
    chk(txd == 1'b1, "R6 idle after release", txd, 1);
    count_until_idle(p, es);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule